// File: doc/BRIEF.md
# Stop-Clock Power-Down Sequencer

This block takes a processor core from normal running into a low-power stop-grant state and back out again. A stop request arrives on an active-low input. That input may be driven from another clock domain. A synchronizer resamples it, and the state machine waits for an instruction boundary before it accepts the request. Once the request is accepted, the block runs a fixed handshake with three neighbours: the pipeline (flush request and done), the bus unit (idle status, plus a special-cycle request that carries a code and waits for acceptance) and the bus termination signals. After those handshakes it drops the core clock enable.

The core remains in stop-grant while the request stays asserted. During that time external logic may also stop the bus clock. Every piece of state is held in plain flops that need no clock activity to keep their values, so a stopped clock loses nothing. When the synchronized request is released, the clock enable is restored and the block returns to running. The bus protocol engine and the clock gating cell itself sit outside this block.

Top module: `stopclk_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `state_o` is 0 (running), `core_clk_en` is 1, and `flush_req`, `spc_req`, `spc_code` and `stop_granted` are all 0.
- R2: A low level on `stop_req_n` passes through a two-stage synchronizer. It moves the block from running (0) to awaiting-boundary (1) on the third rising edge after it is first sampled. A low pulse that lasts two clocks is captured, and the whole sequence then completes even if the request has already been released.
- R3: In awaiting-boundary (1), the block stays put with `flush_req` low for as long as `instr_boundary` is low. It moves to flushing (2) on the edge where `instr_boundary` is sampled high.
- R4: `flush_req` is high exactly while in flushing (2). It stays high until `flush_done` is sampled, and the block then moves to draining (3).
- R5: In draining (3), `spc_req` stays low until `bus_idle` is sampled high. The block then moves to issuing (4).
- R6: In issuing (4), `spc_req` is 1 and `spc_code` equals `ACK_CODE` (default 4). Both are held until `spc_accept` is sampled, and the block then moves to ack-wait (5). `spc_code` is 0 whenever `spc_req` is 0.
- R7: `spc_req` rises exactly once for each accepted request.
- R8: `core_clk_en` falls, and the block enters stop-grant (6), only after both `bus_ready` and `wb_empty` have been sampled high while in ack-wait (5). They may arrive in either order or in the same cycle. Samples taken before ack-wait do not count.
- R9: The `state_o` encoding is: running 0, awaiting-boundary 1, flushing 2, draining 3, issuing 4, ack-wait 5, stop-grant 6. `stop_granted` is 1 exactly in state 6, and `core_clk_en` is 0 exactly in state 6.
- R10: Stop-grant and its outputs hold unchanged for as long as the synchronized request stays asserted.
- R11: In stop-grant, the block returns to running with `core_clk_en` at 1 on the edge after the synchronized request is seen released. That is the third rising edge after `stop_req_n` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_n | input | 1 | Stop request, active low, may be asynchronous |
| instr_boundary | input | 1 | Core is at an instruction boundary |
| flush_req | output | 1 | Pipeline flush request |
| flush_done | input | 1 | Pipeline flush finished |
| bus_idle | input | 1 | No pending or in-progress bus cycles |
| spc_req | output | 1 | Special bus cycle request |
| spc_code | output | CODE_W | Special cycle code (ACK_CODE while requesting) |
| spc_accept | input | 1 | Bus engine accepted the special cycle |
| bus_ready | input | 1 | Ready that terminates the special cycle |
| wb_empty | input | 1 | External write buffers empty |
| core_clk_en | output | 1 | Core clock enable |
| state_o | output | 3 | Current sequencer state |
| stop_granted | output | 1 | In stop-grant |

## Verification
Two events can fall in the same cycle: the ready that ends the special cycle and the write-buffer-empty indication. The clock enable has to drop at the same point whether the two arrive together, in either order, or with one of them seen too early. The bench drives them in all of these ways, and a cycle-accurate model checks that the clock enable falls exactly one edge after the later of the two. A second overlap is a request released before the sequence ends. Here a two-clock pulse carries the block all the way to stop-grant, and the block must leave stop-grant after exactly one cycle.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;
  typedef enum logic [2:0] {
    SC_RUN      = 3'd0,
    SC_WAIT_BND = 3'd1,
    SC_FLUSH    = 3'd2,
    SC_DRAIN    = 3'd3,
    SC_ISSUE    = 3'd4,
    SC_ACKWAIT  = 3'd5,
    SC_GRANT    = 3'd6
  } sc_state_t;
endpackage

// File: rtl/stopclk_sync.sv
module stopclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic req_o
);
  logic [STAGES-1:0] pipe;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[0] <= 1'b0;
        else     pipe[0] <= ~async_n;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= 1'b0;
        else     pipe[g] <= pipe[g-1];
      end
      // R2
      pipe_shift_chk: assert property (@(posedge clk) disable iff (rst)
        pipe[g-1] |=> pipe[g]);
    end
  end

  assign req_o = pipe[STAGES-1];
endmodule

// File: rtl/stopclk_ackwait.sv
module stopclk_ackwait (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic bus_ready,
  input  logic wb_empty,
  output logic done
);
  logic rdy_seen, wbe_seen;

  always_ff @(posedge clk) begin
    if (rst || !armed) begin
      rdy_seen <= 1'b0;
      wbe_seen <= 1'b0;
    end else begin
      rdy_seen <= rdy_seen | bus_ready;
      wbe_seen <= wbe_seen | wb_empty;
    end
  end

  assign done = armed & (rdy_seen | bus_ready) & (wbe_seen | wb_empty);

  // R8
  done_armed_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> armed);
endmodule

// File: rtl/stopclk_fsm.sv
module stopclk_fsm
  import stopclk_pkg::*;
#(
  parameter int          CODE_W   = 4,
  parameter int unsigned ACK_CODE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_s,
  input  logic              instr_boundary,
  input  logic              flush_done,
  input  logic              bus_idle,
  input  logic              spc_accept,
  input  logic              ack_done,
  output logic              armed,
  output sc_state_t         state,
  output logic              flush_req,
  output logic              spc_req,
  output logic [CODE_W-1:0] spc_code,
  output logic              core_clk_en,
  output logic              stop_granted
);
  localparam logic [CODE_W-1:0] CODE_VAL = CODE_W'(ACK_CODE);

  sc_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      SC_RUN:      if (req_s)          nxt = SC_WAIT_BND;
      SC_WAIT_BND: if (instr_boundary) nxt = SC_FLUSH;
      SC_FLUSH:    if (flush_done)     nxt = SC_DRAIN;
      SC_DRAIN:    if (bus_idle)       nxt = SC_ISSUE;
      SC_ISSUE:    if (spc_accept)     nxt = SC_ACKWAIT;
      SC_ACKWAIT:  if (ack_done)       nxt = SC_GRANT;
      SC_GRANT:    if (!req_s)         nxt = SC_RUN;
      default:                         nxt = SC_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SC_RUN;
      flush_req    <= 1'b0;
      spc_req      <= 1'b0;
      spc_code     <= '0;
      core_clk_en  <= 1'b1;
      stop_granted <= 1'b0;
    end else begin
      state        <= nxt;
      flush_req    <= (nxt == SC_FLUSH);
      spc_req      <= (nxt == SC_ISSUE);
      spc_code     <= (nxt == SC_ISSUE) ? CODE_VAL : '0;
      core_clk_en  <= (nxt != SC_GRANT);
      stop_granted <= (nxt == SC_GRANT);
    end
  end

  assign armed = (state == SC_ACKWAIT);

  logic issued_q;
  always_ff @(posedge clk) begin
    if (rst || state == SC_RUN) issued_q <= 1'b0;
    else if (spc_req)           issued_q <= 1'b1;
  end

  // R3
  boundary_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SC_WAIT_BND && !instr_boundary) |=> (state == SC_WAIT_BND && !flush_req));
  // R4
  flush_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_req && !flush_done) |=> flush_req);
  // R5
  drain_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SC_DRAIN && !bus_idle) |=> !spc_req);
  // R6
  spc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (spc_req && !spc_accept) |=> (spc_req && $stable(spc_code)));
  // R7
  single_issue_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spc_req) |-> !issued_q);
  // R8
  clk_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(core_clk_en) |-> $past(ack_done));
  // R9
  grant_flag_chk: assert property (@(posedge clk) disable iff (rst)
    stop_granted |-> !core_clk_en);
  // R10
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SC_GRANT && req_s) |=> (state == SC_GRANT && !core_clk_en));
  // R11
  wake_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SC_GRANT && !req_s) |=> (core_clk_en && state == SC_RUN));
endmodule

// File: rtl/stopclk_seq.sv
module stopclk_seq
  import stopclk_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          CODE_W      = 4,
  parameter int unsigned ACK_CODE    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_req_n,
  input  logic              instr_boundary,
  output logic              flush_req,
  input  logic              flush_done,
  input  logic              bus_idle,
  output logic              spc_req,
  output logic [CODE_W-1:0] spc_code,
  input  logic              spc_accept,
  input  logic              bus_ready,
  input  logic              wb_empty,
  output logic              core_clk_en,
  output logic [2:0]        state_o,
  output logic              stop_granted
);
  logic      req_s;
  logic      armed;
  logic      ack_done;
  sc_state_t state;

  stopclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_n (stop_req_n),
    .req_o   (req_s)
  );

  stopclk_ackwait u_ackwait (
    .clk       (clk),
    .rst       (rst),
    .armed     (armed),
    .bus_ready (bus_ready),
    .wb_empty  (wb_empty),
    .done      (ack_done)
  );

  stopclk_fsm #(.CODE_W(CODE_W), .ACK_CODE(ACK_CODE)) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .req_s          (req_s),
    .instr_boundary (instr_boundary),
    .flush_done     (flush_done),
    .bus_idle       (bus_idle),
    .spc_accept     (spc_accept),
    .ack_done       (ack_done),
    .armed          (armed),
    .state          (state),
    .flush_req      (flush_req),
    .spc_req        (spc_req),
    .spc_code       (spc_code),
    .core_clk_en    (core_clk_en),
    .stop_granted   (stop_granted)
  );

  assign state_o = state;
endmodule

// File: tb/stopclk_seq_tb.sv
module stopclk_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stop_req_n = 1'b1;
  logic       instr_boundary = 1'b0;
  logic       flush_done = 1'b0;
  logic       bus_idle = 1'b0;
  logic       spc_accept = 1'b0;
  logic       bus_ready = 1'b0;
  logic       wb_empty = 1'b0;
  logic       flush_req, spc_req, core_clk_en, stop_granted;
  logic [3:0] spc_code;
  logic [2:0] state_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  int spc_rises = 0;
  int base;
  bit spc_prev = 1'b0;
  bit started = 1'b0;

  stopclk_seq u_dut (
    .clk(clk), .rst(rst), .stop_req_n(stop_req_n), .instr_boundary(instr_boundary),
    .flush_req(flush_req), .flush_done(flush_done), .bus_idle(bus_idle),
    .spc_req(spc_req), .spc_code(spc_code), .spc_accept(spc_accept),
    .bus_ready(bus_ready), .wb_empty(wb_empty), .core_clk_en(core_clk_en),
    .state_o(state_o), .stop_granted(stop_granted)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_st = 0;
  int m_n;
  bit m_r, m_rs, m_ws;
  bit pipe[$];

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_st = 0; m_rs = 0; m_ws = 0;
      pipe = '{1'b0, 1'b0};
      started = 1'b1;
    end else begin
      m_r = pipe.pop_front();
      pipe.push_back(!stop_req_n);
      m_n = m_st;
      case (m_st)
        0: if (m_r) m_n = 1;
        1: if (instr_boundary) m_n = 2;
        2: if (flush_done) m_n = 3;
        3: if (bus_idle) m_n = 4;
        4: if (spc_accept) m_n = 5;
        5: if ((m_rs || bus_ready) && (m_ws || wb_empty)) m_n = 6;
        6: if (!m_r) m_n = 0;
        default: m_n = 0;
      endcase
      if (m_st == 5 && m_n == 5) begin
        m_rs = m_rs | bus_ready;
        m_ws = m_ws | wb_empty;
      end else begin
        m_rs = 0; m_ws = 0;
      end
      m_st = m_n;
    end
    if (cycles == 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R9 state", state_o, m_st);
      chk("R8 clk_en", core_clk_en, m_st != 6);
      chk("R4 flush_req", flush_req, m_st == 2);
      chk("R6 spc_req", spc_req, m_st == 4);
      chk("R6 spc_code", spc_code, (m_st == 4) ? 4 : 0);
      chk("R9 granted", stop_granted, m_st == 6);
      if (spc_req && !spc_prev) spc_rises++;
      spc_prev = spc_req;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(input int s);
    while (state_o != 3'(s)) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R1 state", state_o, 0);
    chk("R1 clk_en", core_clk_en, 1);
    chk("R1 flush", flush_req, 0);
    chk("R1 spc", spc_req, 0);
    chk("R1 granted", stop_granted, 0);

    // sequence 1: slow handshakes, ready before write-buffer-empty
    base = spc_rises;
    stop_req_n = 1'b0;
    cyc(2);
    chk("R2 not yet", state_o, 0);
    cyc(1);
    chk("R2 recognized", state_o, 1);
    cyc(5);
    chk("R3 waiting", state_o, 1);
    chk("R3 no flush", flush_req, 0);
    instr_boundary = 1'b1;
    cyc(1);
    instr_boundary = 1'b0;
    chk("R4 flush up", flush_req, 1);
    cyc(3);
    chk("R4 flush held", flush_req, 1);
    flush_done = 1'b1;
    cyc(1);
    flush_done = 1'b0;
    chk("R4 drain", state_o, 3);
    cyc(4);
    chk("R5 no spc", spc_req, 0);
    bus_idle = 1'b1;
    cyc(1);
    chk("R6 spc up", spc_req, 1);
    chk("R6 code", spc_code, 4);
    cyc(3);
    chk("R6 spc held", spc_req, 1);
    spc_accept = 1'b1;
    cyc(1);
    spc_accept = 1'b0;
    chk("R6 spc down", spc_req, 0);
    bus_ready = 1'b1;
    cyc(1);
    bus_ready = 1'b0;
    cyc(3);
    chk("R8 ready only", core_clk_en, 1);
    wb_empty = 1'b1;
    cyc(1);
    chk("R8 gated", core_clk_en, 0);
    chk("R9 granted", stop_granted, 1);
    cyc(20);
    chk("R10 hold state", state_o, 6);
    chk("R10 hold clk_en", core_clk_en, 0);
    chk("R7 one issue", spc_rises - base, 1);
    stop_req_n = 1'b1;
    cyc(2);
    chk("R11 still granted", state_o, 6);
    cyc(1);
    chk("R11 running", state_o, 0);
    chk("R11 clk_en", core_clk_en, 1);

    // sequence 2: two-clock pulse, fast path, ready and wbe together
    wb_empty = 1'b0;
    bus_idle = 1'b1;
    flush_done = 1'b1;
    instr_boundary = 1'b1;
    spc_accept = 1'b1;
    base = spc_rises;
    stop_req_n = 1'b0;
    cyc(2);
    stop_req_n = 1'b1;
    wait_state(5);
    chk("R2 pulse captured", state_o, 5);
    cyc(2);
    chk("R8 none seen", core_clk_en, 1);
    bus_ready = 1'b1;
    wb_empty = 1'b1;
    cyc(1);
    bus_ready = 1'b0;
    wb_empty = 1'b0;
    chk("R8 same cycle", core_clk_en, 0);
    cyc(1);
    chk("R11 released early", state_o, 0);
    chk("R7 one issue", spc_rises - base, 1);

    // sequence 3: wbe early, ready seen before ack-wait ignored
    spc_accept = 1'b0;
    wb_empty = 1'b1;
    base = spc_rises;
    stop_req_n = 1'b0;
    wait_state(4);
    bus_ready = 1'b1;
    cyc(1);
    bus_ready = 1'b0;
    cyc(3);
    spc_accept = 1'b1;
    cyc(1);
    spc_accept = 1'b0;
    chk("R6 ack-wait", state_o, 5);
    cyc(2);
    chk("R8 early ready ignored", core_clk_en, 1);
    bus_ready = 1'b1;
    cyc(1);
    bus_ready = 1'b0;
    chk("R8 gated", core_clk_en, 0);
    cyc(5);
    chk("R10 hold", state_o, 6);
    stop_req_n = 1'b1;
    wait_state(0);
    chk("R7 one issue", spc_rises - base, 1);
    cyc(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule